// File: doc/BRIEF.md
# Two-Wire Target for a Clock/Calendar Register Bank

This block is the serial front end of a clock/calendar: a standard-mode two-wire (I2C) target holding an eight-byte register bank. Seven bytes hold the time and date fields and the last byte is a control byte. The block samples SCL and SDA with the system clock through a short synchronizer. It detects START, repeated START and STOP, and it matches the 7-bit device address. It acknowledges the address byte, the word address and every written byte. SDA is only ever pulled low, through an open-drain enable.

A write transaction loads the register pointer from its first byte after the address. Each later byte is stored and then advances the pointer. A read transaction returns the byte at the pointer, most significant bit first. The pointer advances only when the master acknowledges. A read that is not preceded by a pointer write begins at the pointer value left by the previous access. A power-fail input aborts the access at once, clears the pointer and blinds the bus receiver while it is high. A busy flag tells the clock counter logic, which lies outside this block, to defer its update while time bytes are being read out.

The bus engine uses these states:
- S_IDLE: waiting for START.
- S_ADDR: shifting in the address byte.
- S_ADDR_ACK: driving the address acknowledge.
- S_WORD: shifting in the word address.
- S_WORD_ACK: driving its acknowledge.
- S_WDATA: shifting in a write byte.
- S_WDATA_ACK: driving its acknowledge.
- S_RDATA: shifting a byte out.
- S_RACK: sampling the master acknowledge.
- S_IGNORE: released, waiting for START or STOP.

The transitions are as follows:
- START from any state goes to S_ADDR.
- STOP from any state goes to S_IDLE.
- Power-fail from any state goes to S_IDLE.
- S_ADDR goes to S_ADDR_ACK on an address match. On a mismatch it goes to S_IGNORE.
- S_ADDR_ACK goes to S_WORD for a write or to S_RDATA for a read.
- S_WORD goes to S_WORD_ACK, then to S_WDATA.
- S_WDATA goes to S_WDATA_ACK and back to S_WDATA.
- S_RDATA goes to S_RACK.
- S_RACK goes to S_RDATA on a master ACK or to S_IGNORE on a NACK.

Top module: `rtc_i2c_target`

## Requirements
- R1: The block acknowledges the address bytes D0h (write) and D1h (read), whose 7-bit address is 1101000 and whose last bit is R/W. Any other address byte gets no acknowledge. The block then ignores the bus until the next START, so bytes that follow are neither acknowledged nor stored.
- R2: SDA falling while SCL is high is a START. A START in the middle of a transaction restarts address reception, and the pointer keeps its value.
- R3: In a write, the byte after the address loads the pointer from its low 3 bits; the upper 5 bits are ignored. Each following byte is stored at the pointer, and the pointer then advances, wrapping from 7 to 0.
- R4: In a read, the block sends the byte at the pointer, MSB first. The pointer advances only on a master ACK. After a master NACK the block releases SDA and sends nothing more.
- R5: A read that starts without a pointer write returns data from the pointer value left by the previous access.
- R6: The acknowledge of every accepted byte is SDA held low through the ninth clock's high phase.
- R7: While power-fail is high, SDA is released, nothing is acknowledged or stored, and the pointer is 0 when power returns.
- R8: After reset the control byte (address 7) reads 80h, with the output-level bit 7 at 1 and the frequency-test bit 6 at 0. The other bytes read 00h. SDA is released and read_busy is low.
- R9: read_busy rises when a read byte is loaded from addresses 0 to 6. It stays high through that read and falls on STOP, START, master NACK or power-fail. A read that covers only address 7 leaves it low.
- R10: regs_o carries register k on bits [8k+7:8k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_fail | input | 1 | Supply out of tolerance; aborts and blinds the bus engine |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| read_busy | output | 1 | Time bytes are being read; the clock update must wait |
| regs_o | output | 64 | Register bank contents, byte k at bits [8k+7:8k] |

## Verification
The checks on SDA timing take for granted that the master changes SDA only while SCL is low, except at START and STOP. They also assume each SCL phase lasts many system clocks, so the synchronized SCL is still low when the engine changes its drive. The bench holds every bus phase for ten clocks and moves SDA two clocks after SCL falls. It raises power-fail only during a byte, never inside an acknowledge slot.

// File: rtl/rtc_i2c_pkg.sv
package rtc_i2c_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_ACK,
        S_WORD,
        S_WORD_ACK,
        S_WDATA,
        S_WDATA_ACK,
        S_RDATA,
        S_RACK,
        S_IGNORE
    } bus_state_t;

endpackage

// File: rtl/rtc_i2c_line_sync.sv
module rtc_i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);

    logic [STAGES-1:0] scl_q;
    logic [STAGES-1:0] sda_q;
    logic              scl_p;
    logic              sda_p;

    // Idle bus is high on both lines, so reset to 1.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_i};
            sda_q <= {sda_q[STAGES-2:0], sda_i};
            scl_p <= scl_q[STAGES-1];
            sda_p <= sda_q[STAGES-1];
        end
    end

    assign scl_s    = scl_q[STAGES-1];
    assign sda_s    = sda_q[STAGES-1];
    assign scl_rise = scl_s & ~scl_p;
    assign scl_fall = ~scl_s & scl_p;
    assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/rtc_i2c_regfile.sv
module rtc_i2c_regfile #(
    parameter int          NREG     = 8,
    parameter int          DW       = 8,
    parameter int          PW       = 3,
    parameter logic [7:0]  CTRL_RST = 8'h80
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [PW-1:0]      wr_addr,
    input  logic [DW-1:0]      wr_data,
    input  logic [PW-1:0]      rd_addr,
    output logic [DW-1:0]      rd_data,
    output logic [NREG*DW-1:0] regs_flat
);

    logic [DW-1:0] mem [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [DW-1:0] RST_VAL = (g == NREG - 1) ? DW'(CTRL_RST) : '0;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem[g] <= RST_VAL;
            end else if (wr_en && (wr_addr == PW'(g))) begin
                mem[g] <= wr_data;
            end
        end
        assign regs_flat[g*DW +: DW] = mem[g];
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/rtc_i2c_target.sv
module rtc_i2c_target
    import rtc_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h68,
    parameter int         NREG        = 8,
    parameter int         DW          = 8,
    parameter int         CLOCK_BYTES = 7,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] CTRL_RST    = 8'h80
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pwr_fail,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe,
    output logic               read_busy,
    output logic [NREG*DW-1:0] regs_o
);

    localparam int             PW        = $clog2(NREG);
    localparam int             CW        = $clog2(DW + 1);
    localparam logic [CW-1:0]  LAST_BIT  = CW'(DW - 1);
    localparam logic [CW-1:0]  FULL_BYTE = CW'(DW);
    localparam logic [PW-1:0]  LAST_CLK  = PW'(CLOCK_BYTES - 1);

    bus_state_t    state, state_d;
    logic [PW-1:0] ptr, ptr_d;
    logic [DW-1:0] sh, sh_d;
    logic [DW-1:0] tx, tx_d;
    logic [CW-1:0] bcnt, bcnt_d;
    logic          mack, mack_d;
    logic          busy, busy_d;
    logic          wr_en;
    logic [DW-1:0] rd_data;

    logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

    rtc_i2c_line_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    rtc_i2c_regfile #(
        .NREG     (NREG),
        .DW       (DW),
        .PW       (PW),
        .CTRL_RST (CTRL_RST)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (ptr),
        .wr_data   (sh),
        .rd_addr   (ptr),
        .rd_data   (rd_data),
        .regs_flat (regs_o)
    );

    // Next-state and datapath decisions.
    always_comb begin
        state_d = state;
        ptr_d   = ptr;
        sh_d    = sh;
        tx_d    = tx;
        bcnt_d  = bcnt;
        mack_d  = mack;
        busy_d  = busy;
        wr_en   = 1'b0;

        if (pwr_fail) begin
            state_d = S_IDLE;
            ptr_d   = '0;
            bcnt_d  = '0;
            busy_d  = 1'b0;
        end else if (start_ev) begin
            state_d = S_ADDR;
            bcnt_d  = '0;
            busy_d  = 1'b0;
        end else if (stop_ev) begin
            state_d = S_IDLE;
            busy_d  = 1'b0;
        end else begin
            unique case (state)
                S_IDLE, S_IGNORE: begin
                    state_d = state;
                end
                S_ADDR, S_WORD, S_WDATA: begin
                    if (scl_rise && (bcnt != FULL_BYTE)) begin
                        sh_d   = {sh[DW-2:0], sda_s};
                        bcnt_d = bcnt + 1'b1;
                    end else if (scl_fall && (bcnt == FULL_BYTE)) begin
                        bcnt_d = '0;
                        if (state == S_ADDR) begin
                            state_d = (sh[DW-1:1] == DEV_ADDR) ? S_ADDR_ACK : S_IGNORE;
                        end else if (state == S_WORD) begin
                            ptr_d   = sh[PW-1:0];
                            state_d = S_WORD_ACK;
                        end else begin
                            wr_en   = 1'b1;
                            ptr_d   = ptr + 1'b1;
                            state_d = S_WDATA_ACK;
                        end
                    end
                end
                S_ADDR_ACK: begin
                    if (scl_fall) begin
                        bcnt_d = '0;
                        if (sh[0]) begin
                            state_d = S_RDATA;
                            tx_d    = rd_data;
                            busy_d  = (ptr <= LAST_CLK);
                        end else begin
                            state_d = S_WORD;
                        end
                    end
                end
                S_WORD_ACK, S_WDATA_ACK: begin
                    if (scl_fall) begin
                        bcnt_d  = '0;
                        state_d = S_WDATA;
                    end
                end
                S_RDATA: begin
                    if (scl_fall) begin
                        if (bcnt == LAST_BIT) begin
                            state_d = S_RACK;
                        end else begin
                            tx_d   = {tx[DW-2:0], 1'b0};
                            bcnt_d = bcnt + 1'b1;
                        end
                    end
                end
                S_RACK: begin
                    if (scl_rise) begin
                        mack_d = ~sda_s;
                        if (!sda_s) begin
                            ptr_d = ptr + 1'b1;
                        end
                    end else if (scl_fall) begin
                        bcnt_d = '0;
                        if (mack) begin
                            state_d = S_RDATA;
                            tx_d    = rd_data;
                            busy_d  = busy | (ptr <= LAST_CLK);
                        end else begin
                            state_d = S_IGNORE;
                            busy_d  = 1'b0;
                        end
                    end
                end
                default: begin
                    state_d = S_IDLE;
                end
            endcase
        end
    end

    // State register and datapath registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            ptr   <= '0;
            sh    <= '0;
            tx    <= '0;
            bcnt  <= '0;
            mack  <= 1'b0;
            busy  <= 1'b0;
        end else begin
            state <= state_d;
            ptr   <= ptr_d;
            sh    <= sh_d;
            tx    <= tx_d;
            bcnt  <= bcnt_d;
            mack  <= mack_d;
            busy  <= busy_d;
        end
    end

    // Outputs decoded from the registered state.
    always_comb begin
        sda_oe    = 1'b0;
        read_busy = busy;
        unique case (state)
            S_ADDR_ACK, S_WORD_ACK, S_WDATA_ACK: sda_oe = 1'b1;
            S_RDATA:                             sda_oe = ~tx[DW-1];
            default:                             sda_oe = 1'b0;
        endcase
    end

endmodule

// File: rtl/rtc_i2c_target_chk.sv
module rtc_i2c_target_chk
    import rtc_i2c_pkg::*;
#(
    parameter int PW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pwr_fail,
    input logic          sda_oe,
    input logic          read_busy,
    input logic          scl_s,
    input logic          wr_en,
    input logic [PW-1:0] ptr,
    input bus_state_t    state
);

    // R7: a power failure releases the data line on the next cycle.
    p_pwr_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |=> !sda_oe);

    // R7: a power failure clears the pointer.
    p_pwr_ptr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |=> (ptr == '0));

    // R6: drive changes happen only while the synchronized clock is low.
    p_drive_scl_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_oe) && !$past(pwr_fail)) |-> !scl_s);

    // R3: every stored byte advances the pointer by one, modulo the bank size.
    p_wr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !pwr_fail) |=> (ptr == $past(ptr) + 1'b1));

    // R9: busy is only seen inside a read transfer.
    p_busy_in_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        read_busy |-> (state == S_RDATA || state == S_RACK));

    // R1: an ignored access never drives the line.
    p_ignore_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IGNORE) |-> !sda_oe);

endmodule

bind rtc_i2c_target rtc_i2c_target_chk #(.PW(PW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_fail  (pwr_fail),
    .sda_oe    (sda_oe),
    .read_busy (read_busy),
    .scl_s     (scl_s),
    .wr_en     (wr_en),
    .ptr       (ptr),
    .state     (state)
);

// File: tb/rtc_i2c_target_bench.sv
`timescale 1ns/1ps
module rtc_i2c_target_bench;

    localparam int Q = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_fail = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_oe;
    logic        read_busy;
    logic [63:0] regs_o;
    logic        sda_line;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;
    logic [7:0] exp_mem [8];

    assign sda_line = sda_m & ~sda_oe;

    always #2.5 clk = ~clk;

    rtc_i2c_target u_rtc_i2c_target (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_fail  (pwr_fail),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .read_busy (read_busy),
        .regs_o    (regs_o)
    );

    task automatic hold(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] packed_exp();
        logic [63:0] v;
        for (int k = 0; k < 8; k++) v[k*8 +: 8] = exp_mem[k];
        return v;
    endfunction

    task automatic bus_start();
        sda_m = 1'b1; hold(Q);
        scl_m = 1'b1; hold(Q);
        sda_m = 1'b0; hold(Q);
        scl_m = 1'b0; hold(2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hold(Q);
        scl_m = 1'b1; hold(Q);
        sda_m = 1'b1; hold(Q);
    endtask

    task automatic clock_bit(input bit b, output bit s);
        sda_m = b; hold(Q);
        scl_m = 1'b1; hold(Q/2);
        s = sda_line; hold(Q/2);
        scl_m = 1'b0; hold(2);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        bit s;
        for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
        clock_bit(1'b1, s);
        acked = ~s;
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit give_ack);
        bit s;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, s);
            b[i] = s;
        end
        clock_bit(~give_ack, s);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        bit         a;
        logic [7:0] d;
        for (int k = 0; k < 8; k++) exp_mem[k] = (k == 7) ? 8'h80 : 8'h00;
        hold(4);
        rst_n = 1'b1;
        hold(4);

        // R8 reset state, R10 byte layout
        chk("R8 reset regs", regs_o, 64'h8000_0000_0000_0000);
        chk("R10 layout", regs_o, packed_exp());
        chk("R8 sda released", sda_oe, 0);
        chk("R8 busy low", read_busy, 0);

        // R3 sequential writes from every start pointer, three bytes each
        for (int s = 0; s < 8; s++) begin
            bus_start();
            send_byte(8'hD0, a);   chk("R1 write address ack", a, 1);
            send_byte(8'(s) | 8'hF8 & 8'(s * 8), a);
            chk("R6 word ack", a, 1);
            for (int k = 0; k < 3; k++) begin
                d = 8'(s * 37 + k * 11 + 5);
                send_byte(d, a);
                chk("R6 data ack", a, 1);
                exp_mem[(s + k) % 8] = d;
            end
            bus_stop();
            hold(Q);
            chk("R3 stored bytes", regs_o, packed_exp());
        end

        // R5 after last write (start 7) the pointer wrapped to 2
        bus_start();
        send_byte(8'hD1, a);   chk("R1 read address ack", a, 1);
        recv_byte(d, 1'b0);
        chk("R5 current address after write", d, exp_mem[2]);
        bus_stop();

        // R4 R9 R2 reads from every pointer, then R5 current address
        for (int s = 0; s < 8; s++) begin
            bus_start();
            send_byte(8'hD0, a);
            send_byte(8'(s), a);
            bus_start();
            send_byte(8'hD1, a);   chk("R2 repeated start ack", a, 1);
            recv_byte(d, 1'b1);
            chk("R4 byte 0", d, exp_mem[s]);
            chk("R9 busy after first byte", read_busy, (s <= 6) ? 1 : 0);
            recv_byte(d, 1'b1);
            chk("R4 byte 1", d, exp_mem[(s + 1) % 8]);
            recv_byte(d, 1'b0);
            chk("R4 byte 2", d, exp_mem[(s + 2) % 8]);
            hold(Q);
            chk("R4 released after nack", sda_oe, 0);
            chk("R9 busy dropped on nack", read_busy, 0);
            bus_stop();
            bus_start();
            send_byte(8'hD1, a);
            recv_byte(d, 1'b0);
            chk("R5 current address read", d, exp_mem[(s + 2) % 8]);
            bus_stop();
        end

        // R2 repeated START inside a write keeps the advanced pointer
        bus_start();
        send_byte(8'hD0, a);
        send_byte(8'h04, a);
        send_byte(8'h3C, a);
        exp_mem[4] = 8'h3C;
        bus_start();
        send_byte(8'hD1, a);
        recv_byte(d, 1'b0);
        chk("R2 read after repeated start", d, exp_mem[5]);
        bus_stop();

        // R1 foreign addresses are not acknowledged and store nothing
        for (int j = 0; j < 3; j++) begin
            bus_start();
            send_byte((j == 0) ? 8'hA0 : (j == 1) ? 8'hD2 : 8'h50, a);
            chk("R1 foreign address nack", a, 0);
            send_byte(8'h00, a);
            send_byte(8'h5A, a);
            chk("R1 ignored byte nack", a, 0);
            bus_stop();
            hold(Q);
            chk("R1 regs unchanged", regs_o, packed_exp());
        end

        // R7 power fail mid byte, then a blind transaction, then recovery
        bus_start();
        send_byte(8'hD0, a);
        send_byte(8'h03, a);
        for (int i = 7; i >= 4; i--) clock_bit(1'b0, a);
        pwr_fail = 1'b1;
        hold(4);
        chk("R7 released on power fail", sda_oe, 0);
        for (int i = 3; i >= 0; i--) clock_bit(1'b1, a);
        clock_bit(1'b1, a);
        chk("R7 no ack during power fail", a, 1);
        bus_stop();
        bus_start();
        send_byte(8'hD0, a);
        chk("R7 address ignored during power fail", a, 0);
        send_byte(8'h02, a);
        send_byte(8'hEE, a);
        bus_stop();
        pwr_fail = 1'b0;
        hold(Q);
        chk("R7 regs unchanged", regs_o, packed_exp());
        bus_start();
        send_byte(8'hD1, a);
        recv_byte(d, 1'b0);
        chk("R7 pointer cleared", d, exp_mem[0]);
        bus_stop();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule